// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block takes a 16-bit command word from a register write port, decodes it, and changes the state of one or all hot-plug slots, or the bus speed/mode setting of the segment behind them. Each slot keeps three items: a slot state (power-only, enabled or disabled), a power indicator and an attention indicator. Each indicator can be on, off or blinking. A single slot command byte carries three independent 2-bit fields, one for each item, and a field of zero leaves its item unchanged.

A command reports busy for a fixed number of cycles. When busy falls, the block applies the command's effects, latches an error code in the status word and raises a one-cycle completion pulse for the event aggregator. A command that fails leaves all state unchanged. The block also drives the indicator lamp outputs, and a blinking indicator toggles at a divided clock rate.

Top module: `hpc_cmd_exec`

## Requirements
- R1: The command word carries the opcode in bits 7:0 and the target slot in bits 15:8. Slot numbers are one-based: value k addresses slot index k-1. A bus-wide command must carry slot value 0.
- R2: Opcodes 00h–3Fh are slot commands. Bits 1:0 set the slot state (1 power-only, 2 enabled, 3 disabled). Bits 3:2 set the power indicator and bits 5:4 set the attention indicator (1 on, 2 blink, 3 off). A field of 0 keeps its item. Each slot reads back these codes in its 2-bit field at [2i+1:2i] of the packed outputs.
- R3: After reset every slot is disabled (3) with both indicators off (3), the bus mode is 0 and the status word is 0.
- R4: An accepted write sets status bit 0 (busy) for exactly BUSY_CYCLES cycles, starting the cycle after the write. Effects and error bits appear in the first cycle with busy low, and done_o is high for that one cycle only.
- R5: A write that arrives while busy is high is ignored. This includes a write in the final busy cycle.
- R6: A slot command whose state field is 1 or 2 is refused when that slot's latch_open_i bit is 1. The refusal sets status bit 1 and changes nothing. A command with a state field of 0 or 3 runs normally on an open latch.
- R7: Status bit 2 is set, and nothing changes, for any of these: a slot command with slot 0 or a slot above N_SLOTS; a bus-wide command with a nonzero slot; the reserved opcodes 45h–47h, 4Ah–4Fh, 5Eh–FFh.
- R8: Opcodes 40h–44h set the bus mode to opcode−40h. Opcodes 50h–5Dh set it to opcode−50h.
- R9: With PROG_IF = 1 (the default), a mode code above 4 is refused. The refusal sets status bit 3 and leaves the mode unchanged.
- R10: Opcode 48h puts every slot in power-only state and 49h enables every slot. If any latch is open, either opcode is refused with status bit 1 and changes nothing.
- R11: A lamp output is 1 for on and 0 for off. For blink it follows a phase that starts at 0 after reset and inverts every BLINK_DIV cycles.
- R12: Accepting a write clears the error bits. At most one error bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 16 | Command word |
| latch_open_i | input | N_SLOTS | Latch sensor per slot, 1 = open |
| status_o | output | 16 | Bit 0 busy, bits 3:1 error, rest 0 |
| slot_state_o | output | 2*N_SLOTS | Packed slot state codes |
| pwr_ind_o | output | 2*N_SLOTS | Packed power indicator codes |
| attn_ind_o | output | 2*N_SLOTS | Packed attention indicator codes |
| pwr_led_o | output | N_SLOTS | Power lamp drive |
| attn_led_o | output | N_SLOTS | Attention lamp drive |
| bus_mode_o | output | 4 | Current bus speed/mode code |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: the completion of a running command and a fresh write to the command register. The bench places a write in the last busy cycle, which is the cycle in which the completion commits. It judges the result by checking that the write's target indicator keeps its old code and that no second busy period follows. A second overlap is an indicator change that lands on a blink phase edge. The behavioural model follows each lamp on every cycle, so a change at that edge is compared in the same cycle in which it occurs.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam logic [1:0] ST_PWR_ONLY = 2'd1;
  localparam logic [1:0] ST_ENABLED  = 2'd2;
  localparam logic [1:0] ST_DISABLED = 2'd3;
  localparam logic [1:0] IND_ON      = 2'd1;
  localparam logic [1:0] IND_BLINK   = 2'd2;
  localparam logic [1:0] IND_OFF     = 2'd3;

  // error vector bit positions (status bits 3:1)
  localparam int ERR_LATCH = 0;
  localparam int ERR_CMD   = 1;
  localparam int ERR_SPEED = 2;

  typedef struct packed {
    logic [1:0] st;
    logic [1:0] pi;
    logic [1:0] ai;
  } slot_upd_t;
endpackage

// File: rtl/hpc_blink_gen.sv
module hpc_blink_gen #(
  parameter int BLINK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int BW = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [BW-1:0] LAST = BW'(BLINK_DIV - 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(phase_o)); // R11
endmodule

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
  import hpc_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int PROG_IF = 1
) (
  input  logic [15:0]        cmd_i,
  input  logic [N_SLOTS-1:0] latch_open_i,
  output logic [2:0]         err_o,
  output logic [N_SLOTS-1:0] slot_we_o,
  output slot_upd_t          upd_o,
  output logic               mode_we_o,
  output logic [3:0]         mode_o
);
  localparam logic [7:0] NS8 = 8'(N_SLOTS);

  logic [7:0] op, sl;
  logic       sl_ok, sel_open, any_open;
  logic [N_SLOTS-1:0] sl_hit;
  logic [7:0] ext_code;

  assign op = cmd_i[7:0];
  assign sl = cmd_i[15:8];
  assign sl_ok = (sl != 8'd0) && (sl <= NS8);
  assign any_open = |latch_open_i;
  assign ext_code = op - 8'h50;

  always_comb begin
    sel_open = 1'b0;
    for (int i = 0; i < N_SLOTS; i++) begin
      sl_hit[i] = (sl == 8'(i + 1));
      if (sl_hit[i]) sel_open = latch_open_i[i];
    end
  end

  always_comb begin
    err_o     = '0;
    slot_we_o = '0;
    upd_o     = '0;
    mode_we_o = 1'b0;
    mode_o    = '0;
    if (op[7:6] == 2'b00) begin
      if (!sl_ok) begin
        err_o[ERR_CMD] = 1'b1;
      end else if ((op[1:0] == ST_PWR_ONLY || op[1:0] == ST_ENABLED) && sel_open) begin
        err_o[ERR_LATCH] = 1'b1;
      end else begin
        slot_we_o = sl_hit;
        upd_o     = '{st: op[1:0], pi: op[3:2], ai: op[5:4]};
      end
    end else if (op >= 8'h40 && op <= 8'h44) begin
      if (sl != 8'd0) err_o[ERR_CMD] = 1'b1;
      else begin
        mode_we_o = 1'b1;
        mode_o    = {1'b0, op[2:0]};
      end
    end else if (op == 8'h48 || op == 8'h49) begin
      if (sl != 8'd0) err_o[ERR_CMD] = 1'b1;
      else if (any_open) err_o[ERR_LATCH] = 1'b1;
      else begin
        slot_we_o = '1;
        upd_o     = '{st: op[0] ? ST_ENABLED : ST_PWR_ONLY, pi: 2'd0, ai: 2'd0};
      end
    end else if (op >= 8'h50 && op <= 8'h5D) begin
      if (sl != 8'd0) err_o[ERR_CMD] = 1'b1;
      else if (PROG_IF == 1 && ext_code > 8'd4) err_o[ERR_SPEED] = 1'b1;
      else begin
        mode_we_o = 1'b1;
        mode_o    = ext_code[3:0];
      end
    end else begin
      err_o[ERR_CMD] = 1'b1;
    end
  end
endmodule

// File: rtl/hpc_slot_ctl.sv
module hpc_slot_ctl
  import hpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  slot_upd_t  upd_i,
  input  logic       phase_i,
  output logic [1:0] state_o,
  output logic [1:0] pwr_ind_o,
  output logic [1:0] attn_ind_o,
  output logic       pwr_led_o,
  output logic       attn_led_o
);
  function automatic logic lamp(input logic [1:0] code, input logic ph);
    case (code)
      IND_ON:    lamp = 1'b1;
      IND_BLINK: lamp = ph;
      default:   lamp = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o    <= ST_DISABLED;
      pwr_ind_o  <= IND_OFF;
      attn_ind_o <= IND_OFF;
    end else if (we_i) begin
      if (upd_i.st != 2'd0) state_o    <= upd_i.st;
      if (upd_i.pi != 2'd0) pwr_ind_o  <= upd_i.pi;
      if (upd_i.ai != 2'd0) attn_ind_o <= upd_i.ai;
    end
  end

  assign pwr_led_o  = lamp(pwr_ind_o, phase_i);
  assign attn_led_o = lamp(attn_ind_o, phase_i);

  AST_HOLD_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable({state_o, pwr_ind_o, attn_ind_o})); // R5
  AST_CODES_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd0 && pwr_ind_o != 2'd0 && attn_ind_o != 2'd0); // R2
endmodule

// File: rtl/hpc_cmd_exec.sv
module hpc_cmd_exec
  import hpc_pkg::*;
#(
  parameter int N_SLOTS     = 4,
  parameter int BUSY_CYCLES = 8,
  parameter int BLINK_DIV   = 4,
  parameter int PROG_IF     = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_we_i,
  input  logic [15:0]            cmd_wdata_i,
  input  logic [N_SLOTS-1:0]     latch_open_i,
  output logic [15:0]            status_o,
  output logic [2*N_SLOTS-1:0]   slot_state_o,
  output logic [2*N_SLOTS-1:0]   pwr_ind_o,
  output logic [2*N_SLOTS-1:0]   attn_ind_o,
  output logic [N_SLOTS-1:0]     pwr_led_o,
  output logic [N_SLOTS-1:0]     attn_led_o,
  output logic [3:0]             bus_mode_o,
  output logic                   done_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYCLES - 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   cmd_q;
  logic [2:0]    err_q, dec_err;
  logic [3:0]    mode_q, dec_mode;
  logic          accept, finish, commit, dec_mode_we, phase;
  logic [N_SLOTS-1:0] dec_slot_we;
  slot_upd_t     dec_upd;

  assign accept = cmd_we_i && !busy_q;
  assign finish = busy_q && (cnt_q == '0);
  assign commit = finish && (dec_err == 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      err_q  <= '0;
      mode_q <= '0;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
        cmd_q  <= cmd_wdata_i;
        err_q  <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= dec_err;
        if (dec_mode_we) mode_q <= dec_mode;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  hpc_cmd_decode #(.N_SLOTS(N_SLOTS), .PROG_IF(PROG_IF)) u_dec (
    .cmd_i       (cmd_q),
    .latch_open_i(latch_open_i),
    .err_o       (dec_err),
    .slot_we_o   (dec_slot_we),
    .upd_o       (dec_upd),
    .mode_we_o   (dec_mode_we),
    .mode_o      (dec_mode)
  );

  hpc_blink_gen #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase)
  );

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    hpc_slot_ctl u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (commit && dec_slot_we[g]),
      .upd_i     (dec_upd),
      .phase_i   (phase),
      .state_o   (slot_state_o[2*g+:2]),
      .pwr_ind_o (pwr_ind_o[2*g+:2]),
      .attn_ind_o(attn_ind_o[2*g+:2]),
      .pwr_led_o (pwr_led_o[g]),
      .attn_led_o(attn_led_o[g])
    );
  end

  assign status_o   = {12'd0, err_q, busy_q};
  assign bus_mode_o = mode_q;
  assign done_o     = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q && $past(busy_q)); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q); // R4
  AST_IGNORE_BUSY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cmd_q)); // R5
  AST_ERR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(err_q)); // R12
  AST_MODE_ONLY_ON_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !finish |=> $stable(mode_q)); // R8
endmodule

// File: tb/tb_hpc_cmd_exec.sv
module tb_hpc_cmd_exec;
  localparam int N = 4;
  localparam int B = 8;
  localparam int BD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [15:0] wdata = '0;
  logic [N-1:0] latch = '0;
  logic [15:0] status;
  logic [2*N-1:0] st_o, pi_o, ai_o;
  logic [N-1:0] pled, aled;
  logic [3:0] mode;
  logic done;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  hpc_cmd_exec #(.N_SLOTS(N), .BUSY_CYCLES(B), .BLINK_DIV(BD), .PROG_IF(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_wdata_i(wdata),
    .latch_open_i(latch), .status_o(status), .slot_state_o(st_o),
    .pwr_ind_o(pi_o), .attn_ind_o(ai_o), .pwr_led_o(pled), .attn_led_o(aled),
    .bus_mode_o(mode), .done_o(done)
  );

  // behavioural reference model
  int ms[N], mp[N], ma[N];
  int mmode, mcnt, mcmd, merr, bcnt;
  bit mbusy, mdone, bph;

  task automatic m_exec();
    int op = mcmd & 255;
    int sl = mcmd >> 8;
    if (op < 64) begin
      if (sl < 1 || sl > N) merr = 2;
      else if (((op & 3) == 1 || (op & 3) == 2) && latch[sl-1]) merr = 1;
      else begin
        if ((op & 3) != 0) ms[sl-1] = op & 3;
        if (((op >> 2) & 3) != 0) mp[sl-1] = (op >> 2) & 3;
        if (((op >> 4) & 3) != 0) ma[sl-1] = (op >> 4) & 3;
      end
    end else if (op >= 64 && op <= 68) begin
      if (sl != 0) merr = 2; else mmode = op - 64;
    end else if (op == 72 || op == 73) begin
      if (sl != 0) merr = 2;
      else if (latch != 0) merr = 1;
      else for (int i = 0; i < N; i++) ms[i] = (op == 72) ? 1 : 2;
    end else if (op >= 80 && op <= 93) begin
      if (sl != 0) merr = 2;
      else if (op - 80 > 4) merr = 4;
      else mmode = op - 80;
    end else merr = 2;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin ms[i] = 3; mp[i] = 3; ma[i] = 3; end
      mmode = 0; mcnt = 0; mcmd = 0; merr = 0; mbusy = 0; mdone = 0; bcnt = 0; bph = 0;
    end else begin
      if (bcnt == BD - 1) begin bcnt = 0; bph = ~bph; end else bcnt++;
      mdone = 0;
      if (mbusy) begin
        if (mcnt == 0) begin m_exec(); mbusy = 0; mdone = 1; end
        else mcnt--;
      end else if (we) begin
        mbusy = 1; mcnt = B - 1; mcmd = wdata; merr = 0;
      end
    end
  end

  function automatic bit lamp(int c, bit ph);
    return (c == 1) ? 1'b1 : (c == 2) ? ph : 1'b0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R4 busy", int'(status[0]), int'(mbusy));
    chk("R12 err", int'(status[15:1]), merr);
    chk("R4 done", int'(done), int'(mdone));
    chk("R8 mode", int'(mode), mmode);
    for (int i = 0; i < N; i++) begin
      chk("R2 state", int'(st_o[2*i+:2]), ms[i]);
      chk("R2 pind", int'(pi_o[2*i+:2]), mp[i]);
      chk("R2 aind", int'(ai_o[2*i+:2]), ma[i]);
      chk("R11 pled", int'(pled[i]), int'(lamp(mp[i], bph)));
      chk("R11 aled", int'(aled[i]), int'(lamp(ma[i], bph)));
    end
  end

  task automatic issue(logic [15:0] c);
    @(negedge clk); we = 1'b1; wdata = c;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic run(logic [15:0] c);
    issue(c);
    repeat (B) @(negedge clk);
    chk("R4 done at end", int'(done), 1);
    chk("R4 busy low at end", int'(status[0]), 0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 state", int'(st_o), 'hFF);
    chk("R3 pind", int'(pi_o), 'hFF);
    chk("R3 aind", int'(ai_o), 'hFF);
    chk("R3 mode", int'(mode), 0);
    chk("R3 status", int'(status), 0);

    // slot 2 enable, power blink, attention off
    run(16'h023A);
    chk("R1 R2 state", int'(st_o), 'hFB);
    chk("R2 pind", int'(pi_o), 'hFB);
    chk("R2 aind", int'(ai_o), 'hFF);

    // write during busy and in the final busy cycle are ignored
    issue(16'h0101);
    @(negedge clk); we = 1'b1; wdata = 16'h0311;
    @(negedge clk); we = 1'b0;
    repeat (B - 3) @(negedge clk);
    we = 1'b1; wdata = 16'h0411;
    @(negedge clk); we = 1'b0;
    chk("R4 done", int'(done), 1);
    @(negedge clk);
    chk("R5 no restart", int'(status[0]), 0);
    chk("R5 attn unchanged", int'(ai_o), 'hFF);
    chk("R2 slot1 power-only", int'(st_o), 'hF9);

    // open latch
    latch = 4'b0100;
    run(16'h0302);
    chk("R6 latch err", int'(status), 'h2);
    chk("R6 state kept", int'(st_o), 'hF9);
    run(16'h0310);
    chk("R6 state-0 allowed", int'(status), 0);
    chk("R6 attn on", int'(ai_o), 'hDF);

    // invalid commands
    run(16'h0501); chk("R7 slot>N", int'(status), 'h4);
    run(16'h0001); chk("R7 slot0", int'(status), 'h4);
    run(16'h0045); chk("R7 reserved 45h", int'(status), 'h4);
    run(16'h0140); chk("R7 bus op with slot", int'(status), 'h4);
    run(16'h00C3); chk("R7 reserved C3h", int'(status), 'h4);
    chk("R7 mode kept", int'(mode), 0);
    chk("R7 state kept", int'(st_o), 'hF9);

    // error cleared on accept
    issue(16'h0041);
    chk("R12 err cleared", int'(status), 'h1);
    repeat (B) @(negedge clk);
    chk("R8 mode 1", int'(mode), 1);
    run(16'h0053); chk("R8 mode 3", int'(mode), 3);
    run(16'h0056);
    chk("R9 speed err", int'(status), 'h8);
    chk("R9 mode kept", int'(mode), 3);

    // all-slot commands
    run(16'h0049);
    chk("R10 refused", int'(status), 'h2);
    chk("R10 kept", int'(st_o), 'hF9);
    latch = '0;
    run(16'h0049); chk("R10 all enabled", int'(st_o), 'hAA);
    run(16'h0048); chk("R10 all power-only", int'(st_o), 'h55);

    // blink phase
    p0 = pled[1];
    repeat (BD) @(negedge clk);
    chk("R11 blink toggles", int'(pled[1]), int'(!p0));
    chk("R11 attn on lamp", int'(aled[2]), 1);
    chk("R11 off lamp", int'(pled[0]), 0);
    repeat (3 * BD) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule